// File: doc/BRIEF.md
# Fixed-Point ALU with Status Flags

This block is a 32-bit two's-complement arithmetic and logic unit that accepts one operation per clock. An 8-bit operation code selects the function. The unit reads two operands and a saturation-mode bit. For the halving average it also reads a rounding-mode bit. The result and five status flags are registered on the clock edge that follows the issue. The flags are zero, negative, overflow, carry and input-sign.

The carry flag held in the unit feeds the carry-consuming operations on later cycles, so an operation can chain onto the carry left by the one before it. Compare operations leave the result register unchanged. Each compare shifts its outcome into an 8-entry history register, so software-visible logic downstream can look at the last eight comparisons at once. No floating-point work, register file or instruction decode sits inside the block.

Top module: `fxalu_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, `res_q`, all five flags and `cmp_hist` read zero until the first accepted operation.
- R2: Opcode 0x01 gives x+y, 0x02 gives x−y, 0x29 gives x+1, 0x2A gives x−1 and 0x22 gives −x, all modulo 2^32. The result appears on `res_q` one clock after issue.
- R3: For adder operations, `flag_c` is the carry out of bit 31 (for subtraction, 1 means no borrow), and `flag_v` is the carry into bit 31 XOR the carry out of bit 31.
- R4: Opcode 0x05 gives x+y+C, 0x06 gives x−y+C−1, 0x25 gives x+C and 0x26 gives x+C−1, where C is the value `flag_c` held when the operation issued.
- R5: With `sat_en` high, an adder operation that overflows returns 0x7FFFFFFF when the true result is positive and 0x80000000 when it is negative. `flag_v` and `flag_c` keep their unsaturated values.
- R6: For every operation other than a compare, `flag_z` is set exactly when the registered result is zero, and `flag_n` copies result bit 31.
- R7: Opcode 0x09 returns (x+y)/2 of the signed sum. With `rnd_trunc` high it rounds toward minus infinity. With `rnd_trunc` low it rounds to nearest, with ties to even. It clears `flag_v`, and `flag_c` is the unsigned carry out of x+y.
- R8: Opcode 0x0A (signed) and 0x0B (unsigned, on the 32-bit patterns) set `flag_z` when x equals y and `flag_n` when x < y. They clear `flag_v`, `flag_c` and `flag_s`, and they leave `res_q` unchanged.
- R9: Each compare shifts `cmp_hist` right by one place, so the old bit 0 is lost. The new bit 7 is 1 exactly when x > y. Other operations leave `cmp_hist` unchanged.
- R10: Opcodes 0x21 (pass x), 0x40 (AND), 0x41 (OR), 0x42 (XOR), 0x43 (NOT x), 0x61 (signed MIN) and 0x62 (signed MAX) clear `flag_v` and `flag_c`.
- R11: Opcode 0x63 returns x when |x| < |y|. Otherwise it returns |y| for x ≥ 0 and −|y| for x < 0. It clears `flag_v` and `flag_c`.
- R12: Opcode 0x30 returns |x| and sets `flag_s` exactly when x is negative. Negating 0x80000000, or taking its absolute value, raises `flag_v`. `flag_s` is zero after every other operation.
- R13: A cycle with `op_valid` low, or with an opcode outside the list above, changes neither the result, the flags nor the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Issue the operation on this cycle |
| opcode | input | 8 | Operation code |
| x_in | input | 32 | First operand |
| y_in | input | 32 | Second operand |
| sat_en | input | 1 | Saturate adder overflow |
| rnd_trunc | input | 1 | Average rounding: 1 truncate, 0 nearest-even |
| res_q | output | 32 | Registered result |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag, also the carry-in for later operations |
| flag_s | output | 1 | Input-sign flag of absolute value |
| cmp_hist | output | 8 | Compare history, newest in bit 7 |

## Verification
The bench first runs a chain of operations in which each carry-consuming step depends on the carry left by the step before it. A design that read the carry combinationally, or dropped it, would return sums that are off by one. Overflow is driven at both signed limits with saturation on and off, including negation and absolute value of 0x80000000. A design that chose the limit from the wrong sign, or derived the zero flag before saturation, would return the opposite limit or the wrong flag. The average is probed on odd sums of both signs in both rounding modes, where a design that rounded ties away from zero or shifted the unsigned sum gives a value one step off. The tests also cover clip at equal magnitudes, history overflow past eight entries, illegal opcodes and idle cycles. These expose a design that writes the result on a compare or shifts the history the wrong way.

// File: rtl/fxalu_pkg.sv
package fxalu_pkg;

    typedef enum logic [7:0] {
        OP_ADD  = 8'h01,
        OP_SUB  = 8'h02,
        OP_ADC  = 8'h05,
        OP_SBB  = 8'h06,
        OP_AVG  = 8'h09,
        OP_CMP  = 8'h0A,
        OP_CMPU = 8'h0B,
        OP_PASS = 8'h21,
        OP_NEG  = 8'h22,
        OP_XPC  = 8'h25,
        OP_XPCM = 8'h26,
        OP_INC  = 8'h29,
        OP_DEC  = 8'h2A,
        OP_ABS  = 8'h30,
        OP_AND  = 8'h40,
        OP_OR   = 8'h41,
        OP_XOR  = 8'h42,
        OP_NOT  = 8'h43,
        OP_MIN  = 8'h61,
        OP_MAX  = 8'h62,
        OP_CLIP = 8'h63
    } alu_op_e;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_ARITH,
        CLS_AVG,
        CLS_CMP,
        CLS_SEL
    } op_class_e;

    typedef struct packed {
        logic z;
        logic n;
        logic v;
        logic c;
        logic s;
    } alu_flags_t;

endpackage

// File: rtl/fxalu_arith.sv
module fxalu_arith
    import fxalu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic              carry_i,
    input  logic              sat_i,
    output logic [DATA_W-1:0] res_o,
    output logic              ovf_o,
    output logic              carry_o,
    output logic              sign_o
);
    localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
    logic              cin;
    logic [DATA_W:0]   wide;
    logic [DATA_W-1:0] raw;
    logic              c_into_msb;

    always_comb begin
        opa    = x_i;
        opb    = '0;
        cin    = 1'b0;
        sign_o = 1'b0;
        unique case (op_i)
            OP_ADD:  opb = y_i;
            OP_SUB:  begin opb = ~y_i; cin = 1'b1;    end
            OP_ADC:  begin opb = y_i;  cin = carry_i; end
            OP_SBB:  begin opb = ~y_i; cin = carry_i; end
            OP_XPC:  cin = carry_i;
            OP_XPCM: begin opb = '1;   cin = carry_i; end
            OP_INC:  cin = 1'b1;
            OP_DEC:  opb = '1;
            OP_NEG:  begin opa = '0; opb = ~x_i; cin = 1'b1; end
            OP_ABS: begin
                sign_o = x_i[DATA_W-1];
                if (x_i[DATA_W-1]) begin
                    opa = '0;
                    opb = ~x_i;
                    cin = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        wide       = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, cin};
        raw        = wide[DATA_W-1:0];
        carry_o    = wide[DATA_W];
        c_into_msb = raw[DATA_W-1] ^ opa[DATA_W-1] ^ opb[DATA_W-1];
        ovf_o      = c_into_msb ^ wide[DATA_W];
        if (ovf_o && sat_i) begin
            res_o = raw[DATA_W-1] ? MAX_POS : MIN_NEG;
        end else begin
            res_o = raw;
        end
    end

endmodule

// File: rtl/fxalu_avg.sv
module fxalu_avg #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic              trunc_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o
);
    logic [DATA_W:0]   ssum;
    logic [DATA_W-1:0] half;
    logic              frac;
    logic              c_into_msb;

    always_comb begin
        ssum = {x_i[DATA_W-1], x_i} + {y_i[DATA_W-1], y_i};
        half = ssum[DATA_W:1];
        frac = ssum[0];
        if (!trunc_i && frac && half[0]) begin
            res_o = half + 1'b1;
        end else begin
            res_o = half;
        end
        c_into_msb = ssum[DATA_W-1] ^ x_i[DATA_W-1] ^ y_i[DATA_W-1];
        carry_o    = (x_i[DATA_W-1] & y_i[DATA_W-1])
                   | ((x_i[DATA_W-1] ^ y_i[DATA_W-1]) & c_into_msb);
    end

endmodule

// File: rtl/fxalu_select.sv
module fxalu_select
    import fxalu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    output logic [DATA_W-1:0] res_o
);
    logic [DATA_W:0] sx;
    logic [DATA_W:0] sy;
    logic [DATA_W:0] mag_x;
    logic [DATA_W:0] mag_y;
    logic            x_lt_y;
    logic [DATA_W-1:0] clip_res;

    always_comb begin
        sx     = {x_i[DATA_W-1], x_i};
        sy     = {y_i[DATA_W-1], y_i};
        mag_x  = sx[DATA_W] ? (~sx + 1'b1) : sx;
        mag_y  = sy[DATA_W] ? (~sy + 1'b1) : sy;
        x_lt_y = $signed(x_i) < $signed(y_i);
        if (mag_x < mag_y) begin
            clip_res = x_i;
        end else if (x_i[DATA_W-1]) begin
            clip_res = ~mag_y[DATA_W-1:0] + 1'b1;
        end else begin
            clip_res = mag_y[DATA_W-1:0];
        end
    end

    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = x_i & y_i;
            OP_OR:   res_o = x_i | y_i;
            OP_XOR:  res_o = x_i ^ y_i;
            OP_NOT:  res_o = ~x_i;
            OP_MIN:  res_o = x_lt_y ? x_i : y_i;
            OP_MAX:  res_o = x_lt_y ? y_i : x_i;
            OP_CLIP: res_o = clip_res;
            default: res_o = x_i;
        endcase
    end

endmodule

// File: rtl/fxalu_cmp_hist.sv
module fxalu_cmp_hist #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic              unsigned_i,
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    output logic              eq_o,
    output logic              lt_o,
    output logic [HIST_W-1:0] hist_o
);
    logic gt;

    always_comb begin
        eq_o = (x_i == y_i);
        lt_o = unsigned_i ? (x_i < y_i) : ($signed(x_i) < $signed(y_i));
        gt   = !eq_o && !lt_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_o <= '0;
        end else if (fire_i) begin
            hist_o <= {gt, hist_o[HIST_W-1:1]};
        end
    end

    // R9
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> (hist_o[HIST_W-2:0] == $past(hist_o[HIST_W-1:1]))
                && (hist_o[HIST_W-1] == ($past(!eq_o) && $past(!lt_o))));

    // R9
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> $stable(hist_o));

endmodule

// File: rtl/fxalu_top.sv
module fxalu_top
    import fxalu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] y_in,
    input  logic              sat_en,
    input  logic              rnd_trunc,
    output logic [DATA_W-1:0] res_q,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_v,
    output logic              flag_c,
    output logic              flag_s,
    output logic [HIST_W-1:0] cmp_hist
);
    localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    alu_op_e           op;
    op_class_e         cls;
    logic              fire;
    logic              cmp_fire;
    alu_flags_t        flags_q;
    alu_flags_t        nxt_fl;
    logic [DATA_W-1:0] nxt_res;

    logic [DATA_W-1:0] ar_res;
    logic              ar_v;
    logic              ar_c;
    logic              ar_s;
    logic [DATA_W-1:0] av_res;
    logic              av_c;
    logic [DATA_W-1:0] sel_res;
    logic              cmp_eq;
    logic              cmp_lt;

    assign op = alu_op_e'(opcode);

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB, OP_ADC, OP_SBB, OP_XPC, OP_XPCM,
            OP_INC, OP_DEC, OP_NEG, OP_ABS:                   cls = CLS_ARITH;
            OP_AVG:                                           cls = CLS_AVG;
            OP_CMP, OP_CMPU:                                  cls = CLS_CMP;
            OP_PASS, OP_AND, OP_OR, OP_XOR, OP_NOT,
            OP_MIN, OP_MAX, OP_CLIP:                          cls = CLS_SEL;
            default:                                          cls = CLS_NONE;
        endcase
    end

    assign fire     = op_valid && (cls != CLS_NONE);
    assign cmp_fire = op_valid && (cls == CLS_CMP);

    fxalu_arith #(.DATA_W(DATA_W)) arith_i (
        .op_i    (op),
        .x_i     (x_in),
        .y_i     (y_in),
        .carry_i (flags_q.c),
        .sat_i   (sat_en),
        .res_o   (ar_res),
        .ovf_o   (ar_v),
        .carry_o (ar_c),
        .sign_o  (ar_s)
    );

    fxalu_avg #(.DATA_W(DATA_W)) avg_i (
        .x_i     (x_in),
        .y_i     (y_in),
        .trunc_i (rnd_trunc),
        .res_o   (av_res),
        .carry_o (av_c)
    );

    fxalu_select #(.DATA_W(DATA_W)) select_i (
        .op_i  (op),
        .x_i   (x_in),
        .y_i   (y_in),
        .res_o (sel_res)
    );

    fxalu_cmp_hist #(.DATA_W(DATA_W), .HIST_W(HIST_W)) hist_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_i     (cmp_fire),
        .unsigned_i (op == OP_CMPU),
        .x_i        (x_in),
        .y_i        (y_in),
        .eq_o       (cmp_eq),
        .lt_o       (cmp_lt),
        .hist_o     (cmp_hist)
    );

    always_comb begin
        nxt_res = res_q;
        nxt_fl  = '0;
        unique case (cls)
            CLS_ARITH: begin
                nxt_res  = ar_res;
                nxt_fl.v = ar_v;
                nxt_fl.c = ar_c;
                nxt_fl.s = ar_s;
            end
            CLS_AVG: begin
                nxt_res  = av_res;
                nxt_fl.c = av_c;
            end
            CLS_SEL:  nxt_res = sel_res;
            CLS_CMP: begin
                nxt_fl.z = cmp_eq;
                nxt_fl.n = cmp_lt;
            end
            default: ;
        endcase
        if (cls != CLS_CMP) begin
            nxt_fl.z = (nxt_res == '0);
            nxt_fl.n = nxt_res[DATA_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
        end else if (fire) begin
            res_q   <= nxt_res;
            flags_q <= nxt_fl;
        end
    end

    assign flag_z = flags_q.z;
    assign flag_n = flags_q.n;
    assign flag_v = flags_q.v;
    assign flag_c = flags_q.c;
    assign flag_s = flags_q.s;

    // R5
    sat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && sat_en && cls == CLS_ARITH) |=>
            (!flag_v || res_q == MAX_POS || res_q == MIN_NEG));

    // R6
    zn_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cls != CLS_CMP) |=>
            ((flag_z == (res_q == '0)) && (flag_n == res_q[DATA_W-1])));

    // R8
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_fire |=> ($stable(res_q) && !flag_v && !flag_c && !flag_s));

    // R10
    sel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cls == CLS_SEL) |=> (!flag_v && !flag_c && !flag_s));

    // R7
    avg_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cls == CLS_AVG) |=> !flag_v);

    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> ($stable(res_q) && $stable(flags_q)));

endmodule

// File: tb/fxalu_top_tb_top.sv
`timescale 1ns/1ps
module fxalu_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [31:0] x_in = '0;
    logic [31:0] y_in = '0;
    logic        sat_en = 1'b0;
    logic        rnd_trunc = 1'b0;
    logic [31:0] res_q;
    logic        flag_z, flag_n, flag_v, flag_c, flag_s;
    logic [7:0]  cmp_hist;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fxalu_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .opcode    (opcode),
        .x_in      (x_in),
        .y_in      (y_in),
        .sat_en    (sat_en),
        .rnd_trunc (rnd_trunc),
        .res_q     (res_q),
        .flag_z    (flag_z),
        .flag_n    (flag_n),
        .flag_v    (flag_v),
        .flag_c    (flag_c),
        .flag_s    (flag_s),
        .cmp_hist  (cmp_hist)
    );

    // {req[4], op[8], x[32], y[32], sat, trunc, res[32], flags zn vcs [5], hist[8]}
    localparam int NV = 45;
    localparam logic [122:0] VEC [0:NV-1] = '{
        {4'd2,  8'h01, 32'h00000005, 32'h00000007, 1'b0, 1'b0, 32'h0000000C, 5'b00000, 8'h00}, // R2
        {4'd3,  8'h01, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0, 32'h00000000, 5'b10010, 8'h00}, // R3
        {4'd4,  8'h05, 32'h0000000A, 32'h00000014, 1'b0, 1'b0, 32'h0000001F, 5'b00000, 8'h00}, // R4
        {4'd2,  8'h02, 32'h00000003, 32'h00000005, 1'b0, 1'b0, 32'hFFFFFFFE, 5'b01000, 8'h00}, // R2
        {4'd3,  8'h02, 32'h00000005, 32'h00000003, 1'b0, 1'b0, 32'h00000002, 5'b00010, 8'h00}, // R3
        {4'd4,  8'h06, 32'h0000000A, 32'h00000003, 1'b0, 1'b0, 32'h00000007, 5'b00010, 8'h00}, // R4
        {4'd3,  8'h01, 32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0, 32'h80000000, 5'b01100, 8'h00}, // R3
        {4'd5,  8'h01, 32'h7FFFFFFF, 32'h00000001, 1'b1, 1'b0, 32'h7FFFFFFF, 5'b00100, 8'h00}, // R5
        {4'd5,  8'h01, 32'h80000000, 32'h80000000, 1'b1, 1'b0, 32'h80000000, 5'b01110, 8'h00}, // R5
        {4'd5,  8'h06, 32'h80000000, 32'h00000001, 1'b1, 1'b0, 32'h80000000, 5'b01110, 8'h00}, // R5
        {4'd4,  8'h25, 32'h00000010, 32'h00000000, 1'b0, 1'b0, 32'h00000011, 5'b00000, 8'h00}, // R4
        {4'd4,  8'h26, 32'h00000010, 32'h00000000, 1'b0, 1'b0, 32'h0000000F, 5'b00010, 8'h00}, // R4
        {4'd5,  8'h29, 32'h7FFFFFFF, 32'h00000000, 1'b1, 1'b0, 32'h7FFFFFFF, 5'b00100, 8'h00}, // R5
        {4'd2,  8'h2A, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 32'hFFFFFFFF, 5'b01000, 8'h00}, // R2
        {4'd5,  8'h2A, 32'h80000000, 32'h00000000, 1'b1, 1'b0, 32'h80000000, 5'b01110, 8'h00}, // R5
        {4'd2,  8'h22, 32'h00000005, 32'h00000000, 1'b0, 1'b0, 32'hFFFFFFFB, 5'b01000, 8'h00}, // R2
        {4'd6,  8'h22, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 32'h00000000, 5'b10010, 8'h00}, // R6
        {4'd12, 8'h22, 32'h80000000, 32'h00000000, 1'b0, 1'b0, 32'h80000000, 5'b01100, 8'h00}, // R12
        {4'd12, 8'h30, 32'hFFFFFFF9, 32'h00000000, 1'b0, 1'b0, 32'h00000007, 5'b00001, 8'h00}, // R12
        {4'd12, 8'h30, 32'h80000000, 32'h00000000, 1'b1, 1'b0, 32'h7FFFFFFF, 5'b00101, 8'h00}, // R12
        {4'd12, 8'h30, 32'h00000009, 32'h00000000, 1'b0, 1'b0, 32'h00000009, 5'b00000, 8'h00}, // R12
        {4'd3,  8'h01, 32'h80000000, 32'h80000000, 1'b0, 1'b0, 32'h00000000, 5'b10110, 8'h00}, // R3
        {4'd10, 8'h21, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 32'h00000000, 5'b10000, 8'h00}, // R10
        {4'd10, 8'h40, 32'hF0F0F0F0, 32'hFF00FF00, 1'b0, 1'b0, 32'hF000F000, 5'b01000, 8'h00}, // R10
        {4'd10, 8'h41, 32'h0000000F, 32'h000000F0, 1'b0, 1'b0, 32'h000000FF, 5'b00000, 8'h00}, // R10
        {4'd10, 8'h42, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0, 32'h00000000, 5'b10000, 8'h00}, // R10
        {4'd10, 8'h43, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 32'hFFFFFFFF, 5'b01000, 8'h00}, // R10
        {4'd10, 8'h61, 32'hFFFFFFFD, 32'h00000002, 1'b0, 1'b0, 32'hFFFFFFFD, 5'b01000, 8'h00}, // R10
        {4'd10, 8'h62, 32'hFFFFFFFD, 32'h00000002, 1'b0, 1'b0, 32'h00000002, 5'b00000, 8'h00}, // R10
        {4'd11, 8'h63, 32'h00000005, 32'h0000000A, 1'b0, 1'b0, 32'h00000005, 5'b00000, 8'h00}, // R11
        {4'd11, 8'h63, 32'h00000014, 32'hFFFFFFF6, 1'b0, 1'b0, 32'h0000000A, 5'b00000, 8'h00}, // R11
        {4'd11, 8'h63, 32'hFFFFFFEC, 32'h0000000A, 1'b0, 1'b0, 32'hFFFFFFF6, 5'b01000, 8'h00}, // R11
        {4'd11, 8'h63, 32'hFFFFFFF6, 32'h0000000A, 1'b0, 1'b0, 32'hFFFFFFF6, 5'b01000, 8'h00}, // R11
        {4'd7,  8'h09, 32'h00000003, 32'h00000004, 1'b0, 1'b0, 32'h00000004, 5'b00000, 8'h00}, // R7
        {4'd7,  8'h09, 32'h00000001, 32'h00000004, 1'b0, 1'b0, 32'h00000002, 5'b00000, 8'h00}, // R7
        {4'd7,  8'h09, 32'h00000003, 32'h00000004, 1'b0, 1'b1, 32'h00000003, 5'b00000, 8'h00}, // R7
        {4'd7,  8'h09, 32'hFFFFFFFD, 32'h00000000, 1'b0, 1'b1, 32'hFFFFFFFE, 5'b01000, 8'h00}, // R7
        {4'd7,  8'h09, 32'hFFFFFFFD, 32'h00000000, 1'b0, 1'b0, 32'hFFFFFFFE, 5'b01000, 8'h00}, // R7
        {4'd7,  8'h09, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b0, 32'h7FFFFFFF, 5'b00000, 8'h00}, // R7
        {4'd7,  8'h09, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0, 32'hFFFFFFFF, 5'b01010, 8'h00}, // R7
        {4'd8,  8'h0A, 32'h00000005, 32'h00000003, 1'b0, 1'b0, 32'hFFFFFFFF, 5'b00000, 8'h80}, // R8
        {4'd8,  8'h0A, 32'hFFFFFFFF, 32'h00000003, 1'b0, 1'b0, 32'hFFFFFFFF, 5'b01000, 8'h40}, // R8
        {4'd9,  8'h0A, 32'h00000007, 32'h00000007, 1'b0, 1'b0, 32'hFFFFFFFF, 5'b10000, 8'h20}, // R9
        {4'd8,  8'h0B, 32'hFFFFFFFF, 32'h00000003, 1'b0, 1'b0, 32'hFFFFFFFF, 5'b00000, 8'h90}, // R8
        {4'd9,  8'h0B, 32'h00000003, 32'hFFFFFFFF, 1'b0, 1'b0, 32'hFFFFFFFF, 5'b01000, 8'h48}  // R9
    };

    task automatic chk(input string tag, input logic [31:0] r_e,
                       input logic [4:0] f_e, input logic [7:0] h_e);
        logic [4:0] f_a;
        f_a = {flag_z, flag_n, flag_v, flag_c, flag_s};
        checks++;
        if ({res_q, f_a, cmp_hist} !== {r_e, f_e, h_e}) begin
            errors++;
            $display("FAIL %s: res=%h flags=%b hist=%h, expected res=%h flags=%b hist=%h",
                     tag, res_q, f_a, cmp_hist, r_e, f_e, h_e);
        end
    endtask

    task automatic issue(input logic v, input logic [7:0] op, input logic [31:0] x,
                         input logic [31:0] y, input logic s, input logic t);
        op_valid  = v;
        opcode    = op;
        x_in      = x;
        y_in      = y;
        sat_en    = s;
        rnd_trunc = t;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset held", 32'h0, 5'b00000, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 32'h0, 5'b00000, 8'h00);

        for (int i = 0; i < NV; i++) begin
            issue(1'b1, VEC[i][118:111], VEC[i][110:79], VEC[i][78:47],
                  VEC[i][46], VEC[i][45]);
            chk($sformatf("R%0d vector %0d", VEC[i][122:119], i),
                VEC[i][44:13], VEC[i][12:8], VEC[i][7:0]);
        end

        // R13: undefined opcode with valid high
        issue(1'b1, 8'h7F, 32'h00000123, 32'h00000001, 1'b0, 1'b0);
        chk("R13 undefined opcode", 32'hFFFFFFFF, 5'b01000, 8'h48);
        // R13: idle cycle with a legal opcode present
        issue(1'b0, 8'h01, 32'h00000001, 32'h00000001, 1'b0, 1'b0);
        chk("R13 idle cycle", 32'hFFFFFFFF, 5'b01000, 8'h48);

        // R9: fill history with greater-than outcomes, then push one less-than
        for (int k = 0; k < 8; k++) begin
            issue(1'b1, 8'h0A, 32'h00000009, 32'h00000001, 1'b0, 1'b0);
        end
        chk("R9 history full", 32'hFFFFFFFF, 5'b00000, 8'hFF);
        issue(1'b1, 8'h0A, 32'h00000001, 32'h00000009, 1'b0, 1'b0);
        chk("R9 oldest dropped", 32'hFFFFFFFF, 5'b01000, 8'h7F);

        // R4: carry left clear by a compare feeds the next add-with-carry
        issue(1'b1, 8'h05, 32'h00000001, 32'h00000001, 1'b0, 1'b0);
        chk("R4 carry cleared by compare", 32'h00000002, 5'b00000, 8'h7F);

        // R1: reset in mid-run
        op_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset", 32'h0, 5'b00000, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule